// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block is a clocked front end for a byte-wide nonvolatile array. It watches three asynchronous active-low strobes (select, write, output enable) plus an address and a data byte. Byte writes are collected into a page buffer, and a restartable load window holds the page open. When the window lapses with no further write, the whole page is committed in one programming cycle of fixed length. A busy flag is high for the whole of that cycle.

While programming runs, a read of the most recently loaded address returns a status pattern instead of stored data. Bit 7 is the inverse of the written value, and bits 6:0 are the written value. Reads of any other address return the array's old contents. Once the cycle ends, true data is returned. All time constants are clock-cycle parameters. The storage array is a register array inside the block.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset `busy` is 0, `dataOe` is 0, and every array byte reads as 0x00.
- R2: A write starts only when the synchronised strobes show output enable high with select and write low. The address is taken in the cycle the write starts. A write attempt made while output enable is low has no effect.
- R3: The data byte is taken when the write ends, which is when the first of select or write rises. This holds for both write-controlled and select-controlled writes.
- R4: Every accepted write start restarts a load window of `LOAD_CYC` clock cycles. Programming begins only after a full window with no new write and no write still in progress.
- R5: `busy` rises one cycle after the window lapses and stays high for exactly `PROG_CYC` cycles, whatever the number of bytes loaded.
- R6: The upper address bits (above the low `PAGE_W` bits) of the first write in a page fix the page. The low `PAGE_W` bits pick the byte. Upper bits of later writes in the same page are ignored.
- R7: A byte loaded twice in a page keeps the later value. Bytes of the page that were not loaded keep their previous contents.
- R8: While `busy` is high, a read of the last loaded address returns {~d[7], d[6:0]}, and other addresses return the old contents. After `busy` falls, true data is returned.
- R9: `dataOe` is high, and `dataOut` shows data, only while the synchronised select and output enable are low and write is high. Otherwise `dataOut` is 0x00.
- R10: Write strobes that arrive while `busy` is high load nothing and do not open a new load window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Asynchronous chip select, active low |
| weN | input | 1 | Asynchronous write strobe, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, 0x00 when not driven |
| dataOe | output | 1 | High when dataOut carries read data |
| busy | output | 1 | Page programming in progress |

## Verification
Each strobe change takes two clock edges to pass the synchroniser. So a write start, a write end or a change in read enable acts on the third edge after the pin moves, and `dataOe` follows two edges after the pins. `busy` rises one edge after the window lapses, and the array contents change on the same edge that `busy` falls. Read data is combinational from `addr` once enabled. The bench keeps a behavioural model that applies these latencies, and it compares `busy`, `dataOe` and `dataOut` 2 ns after every rising edge, while inputs only change on falling edges. Directed reads hold the strobes for three edges before sampling.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgState_t;

  typedef struct packed {
    logic capAddr;   // take byte offset from addr
    logic firstLoad; // also take page number
    logic capData;   // store dataIn into page buffer
    logic commit;    // write page buffer into array
  } pgStrobe_t;

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import eeprom_page_pkg::*;
#(
  parameter int LOAD_CYC = 40,
  parameter int PROG_CYC = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      weS,
  input  logic      oeS,
  output pgStrobe_t strb,
  output logic      busy,
  output logic      rdEn
);
  localparam int LW = $clog2(LOAD_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [LW-1:0] LOAD_LAST = LW'(LOAD_CYC - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

  pgState_t      state;
  logic [LW-1:0] timer;
  logic [PW-1:0] progCnt;
  logic          pending;
  logic          wrPrev;
  logic          wrAct, startEv, endEv, expire;

  assign wrAct   = oeS & ~csS & ~weS;
  assign startEv = wrAct & ~wrPrev;
  assign endEv   = ~wrAct & wrPrev;
  assign expire  = (state == ST_LOAD) && !startEv && (timer == LOAD_LAST) && !wrAct && !pending;
  assign busy    = (state == ST_PROG);
  assign rdEn    = ~csS & ~oeS & weS;

  always_comb begin
    strb           = '0;
    strb.capAddr   = startEv && (state != ST_PROG);
    strb.firstLoad = startEv && (state == ST_IDLE);
    strb.capData   = endEv && pending;
    strb.commit    = (state == ST_PROG) && (progCnt == PROG_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      progCnt <= '0;
      pending <= 1'b0;
      wrPrev  <= 1'b0;
    end else begin
      wrPrev <= wrAct;
      unique case (state)
        ST_IDLE: if (startEv) begin
          state   <= ST_LOAD;
          timer   <= '0;
          pending <= 1'b1;
        end
        ST_LOAD: begin
          if (startEv) begin
            timer   <= '0;
            pending <= 1'b1;
          end else begin
            if (endEv) pending <= 1'b0;
            if (expire) begin
              state   <= ST_PROG;
              progCnt <= '0;
            end else if (timer != LOAD_LAST) begin
              timer <= timer + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (progCnt == PROG_LAST) state <= ST_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(state) == ST_LOAD));

  // R10
  busy_no_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !pending);

  // R4
  window_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEv && state != ST_PROG) |=> (timer == '0) && (state == ST_LOAD));
endmodule

// File: rtl/pg_dpath.sv
module pg_dpath
  import eeprom_page_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         strb,
  input  logic              busy,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int UP_W   = ADDR_W - PAGE_W;

  logic [7:0]        mem     [DEPTH];
  logic [7:0]        pageBuf [PAGE_N];
  logic [PAGE_N-1:0] validMask;
  logic [UP_W-1:0]   pageAddr;
  logic [PAGE_W-1:0] curOff;
  logic [ADDR_W-1:0] lastAddr;
  logic [7:0]        lastData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMask <= '0;
      pageAddr  <= '0;
      curOff    <= '0;
      lastAddr  <= '0;
      lastData  <= '0;
    end else begin
      if (strb.capAddr) begin
        curOff <= addr[PAGE_W-1:0];
        if (strb.firstLoad) pageAddr <= addr[ADDR_W-1:PAGE_W];
      end
      if (strb.capData) begin
        validMask[curOff] <= 1'b1;
        lastAddr          <= {pageAddr, curOff};
        lastData          <= dataIn;
      end
      if (strb.commit) validMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capData) pageBuf[curOff] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (validMask[i]) mem[{pageAddr, PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  always_comb begin
    if (!rdEn)                          dataOut = 8'h00;
    else if (busy && addr == lastAddr)  dataOut = {~lastData[7], lastData[6:0]};
    else                                dataOut = mem[addr];
  end

  // R7
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (validMask == '0));

  // R3
  data_marks_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capData |=> validMask[$past(curOff)]);

  // R10
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.capData);
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_page_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int PAGE_W   = 7,
  parameter int LOAD_CYC = 40,
  parameter int PROG_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              busy
);
  logic [2:0] strbSync;
  pgStrobe_t  strb;
  logic       rdEn;

  pg_sync #(.W(3), .STAGES(2)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({csN, weN, oeN}),
    .syncOut(strbSync)
  );

  pg_ctrl #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .csS(strbSync[2]), .weS(strbSync[1]), .oeS(strbSync[0]),
    .strb(strb), .busy(busy), .rdEn(rdEn)
  );

  pg_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_dpath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .busy(busy), .rdEn(rdEn),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut)
  );

  assign dataOe = rdEn;
endmodule

// File: tb/test_eeprom_page_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_page_ctrl;
  localparam int ADDR_W = 9, PAGE_W = 7, LOAD_CYC = 40, PROG_CYC = 200;

  logic clk = 0, rstN = 0, csN = 1, weN = 1, oeN = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = '0, dataOut;
  logic dataOe, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC))
    i_eeprom_page_ctrl (.clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
      .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .busy(busy));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mCs1 = 1, mCs2 = 1, mWe1 = 1, mWe2 = 1, mOe1 = 1, mOe2 = 1, mPrev = 0, mPend = 0;
  bit act, st, en, expire;
  int mMode = 0, mTimer = 0, mProg = 0, mPage = 0, mOff = 0, mLastA = 0, mLastD = 0;
  int mem[int];
  int pbuf[int];

  always @(posedge clk) begin
    if (!rstN) begin
      mCs1 = 1; mCs2 = 1; mWe1 = 1; mWe2 = 1; mOe1 = 1; mOe2 = 1; mPrev = 0; mPend = 0;
      mMode = 0; mTimer = 0; mProg = 0; mem.delete(); pbuf.delete();
    end else begin
      act = mOe2 && !mCs2 && !mWe2;
      st  = act && !mPrev;
      en  = !act && mPrev;
      if (st && mMode != 2) begin
        mOff = int'(addr) % (1 << PAGE_W);
        if (mMode == 0) mPage = int'(addr) >> PAGE_W;
      end
      if (en && mPend) begin
        pbuf[mOff] = int'(dataIn);
        mLastA = mPage * (1 << PAGE_W) + mOff;
        mLastD = int'(dataIn);
      end
      case (mMode)
        0: if (st) begin mMode = 1; mTimer = 0; mPend = 1; end
        1: if (st) begin mTimer = 0; mPend = 1; end
           else begin
             expire = (mTimer == LOAD_CYC - 1) && !act && !mPend;
             if (en) mPend = 0;
             if (expire) begin mMode = 2; mProg = 0; end
             else if (mTimer != LOAD_CYC - 1) mTimer++;
           end
        default: if (mProg == PROG_CYC - 1) begin
             foreach (pbuf[k]) mem[mPage * (1 << PAGE_W) + k] = pbuf[k];
             pbuf.delete();
             mMode = 0;
           end else mProg++;
      endcase
      mPrev = act;
      mCs2 = mCs1; mCs1 = csN; mWe2 = mWe1; mWe1 = weN; mOe2 = mOe1; mOe1 = oeN;
    end
  end

  function automatic int expData(int a);
    if (!(!mCs2 && !mOe2 && mWe2)) return 0;
    if (mMode == 2 && a == mLastA) return ((~mLastD) & 8'h80) | (mLastD & 8'h7f);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  // per-clock comparison, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      chk("R5 busy", int'(busy), (mMode == 2) ? 1 : 0);
      chk("R9 dataOe", int'(dataOe), (!mCs2 && !mOe2 && mWe2) ? 1 : 0);
      chk("R8 dataOut", int'(dataOut), expData(int'(addr)));
    end
  end

  int runCnt = 0, lastRun = 0;
  always @(posedge clk) begin
    if (busy) runCnt++;
    else if (runCnt != 0) begin lastRun = runCnt; runCnt = 0; end
  end

  task automatic writeByte(int a, int d, bit csCtl);
    @(negedge clk); addr = ADDR_W'(a); dataIn = 8'(d);
    if (csCtl) begin weN = 0; @(negedge clk); csN = 0; end
    else begin csN = 0; @(negedge clk); weN = 0; end
    repeat (4) @(negedge clk);
    if (csCtl) csN = 1; else weN = 1;
    repeat (4) @(negedge clk);
    csN = 1; weN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic readAt(int a, output int v);
    @(negedge clk); addr = ADDR_W'(a); csN = 0; oeN = 0;
    repeat (3) @(posedge clk);
    #2 v = int'(dataOut);
    @(negedge clk); csN = 1; oeN = 1;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitBusy();
    while (!busy) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 dataOe after reset", int'(dataOe), 0);
    readAt(9'h000, v); chk("R1 array cleared", v, 8'h00);

    // write attempt with output enable low: ignored, no read either
    @(negedge clk); addr = 9'h010; dataIn = 8'h99; oeN = 0; csN = 0; weN = 0;
    repeat (6) @(posedge clk);
    #2 chk("R9 no drive while write low", int'(dataOe), 0);
    @(negedge clk); csN = 1; weN = 1; oeN = 1;
    waitCycles(LOAD_CYC + 20);
    chk("R2 oe-low write ignored", int'(busy), 0);
    readAt(9'h010, v); chk("R2 oe-low write no store", v, 8'h00);

    // single byte, write-controlled
    writeByte(9'h005, 8'hA5, 0);
    waitBusy();
    readAt(9'h005, v); chk("R8 poll pattern", v, 8'h25);
    readAt(9'h006, v); chk("R8 other address old data", v, 8'h00);
    waitIdle();
    chk("R5 one-byte busy length", lastRun, PROG_CYC);
    readAt(9'h005, v); chk("R8 true data after busy", v, 8'hA5);

    // multi-byte page with window restarts
    writeByte(9'h081, 8'h11, 0);
    waitCycles(LOAD_CYC - 15);
    writeByte(9'h182, 8'h22, 0);
    waitCycles(LOAD_CYC - 15);
    chk("R4 window kept open", int'(busy), 0);
    writeByte(9'h081, 8'h33, 0);
    writeByte(9'h083, 8'hC4, 1);
    waitBusy();
    writeByte(9'h090, 8'h77, 0);
    readAt(9'h083, v); chk("R8 poll of select-written byte", v, 8'h44);
    readAt(9'h081, v); chk("R8 old data during busy", v, 8'h00);
    waitIdle();
    chk("R5 four-byte busy length", lastRun, PROG_CYC);
    waitCycles(LOAD_CYC + 20);
    chk("R10 no window from busy write", int'(busy), 0);
    readAt(9'h081, v); chk("R7 later data wins", v, 8'h33);
    readAt(9'h082, v); chk("R6 byte lands in first page", v, 8'h22);
    readAt(9'h182, v); chk("R6 other page untouched", v, 8'h00);
    readAt(9'h083, v); chk("R3 select-controlled data", v, 8'hC4);
    readAt(9'h084, v); chk("R7 unloaded byte", v, 8'h00);
    readAt(9'h090, v); chk("R10 busy write dropped", v, 8'h00);

    // unloaded bytes keep earlier programmed data
    writeByte(9'h006, 8'h5A, 1);
    waitBusy();
    waitIdle();
    readAt(9'h005, v); chk("R7 previous content kept", v, 8'hA5);
    readAt(9'h006, v); chk("R3 new byte stored", v, 8'h5A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R5 actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule